// File: doc/BRIEF.md
# Parallel Bus Transaction Monitor

This block is a passive observer for a 32-bit asynchronous parallel bus. It never drives the bus. Every bus line is oversampled with a fast local clock. The block decodes the roles and the order of the active-low strobes, and turns each complete transfer into one record. A record holds the direction, the memory/I/O space bit, the address, the byte enables, the data word and a flag marking a card-setup access. It does not keep raw samples. The monitor emits one record per transfer, as a single-cycle pulse together with the record fields.

A transfer works as follows. The address and the space select are taken when the address-latch strobe falls. The direction is taken when the transfer strobe falls. Data and byte enables are taken on the sample where the transfer strobe returns high, so read data from the target is included. Some transfer starts are malformed: either no address latch came since the previous record, or neither status line is low. These starts are dropped and counted in a saturating error counter.

A trigger unit compares every record against a programmed pattern. The pattern is either "first card-setup access", or a masked address combined with a required direction and space, such as an I/O write to 0x600. The trigger raises a sticky flag that stays set until the local logic clears it.

Top module: `bus_xact_monitor`

## Requirements
- R1: Every bus input passes through two synchronizer flops, and strobe edges are taken from the synchronized samples. A strobe edge that arrives before clock edge k takes effect on the outputs after edge k+2.
- R2: A transfer opens when `bus_xfer_n` falls and closes when it rises again. Each closed transfer produces exactly one clock of `rec_valid`. A rise of `bus_xfer_n` with no open transfer produces nothing.
- R3: `rec_write` is 1 when `bus_wstat_n` was low at the transfer start. It is 0 when only `bus_rstat_n` was low.
- R4: `rec_addr`, `rec_mem` (1 = memory, 0 = I/O) and `rec_setup` come from the sample on which `bus_alat_n` fell. Later changes of those lines do not alter the record. While a transfer is open, further address-latch edges are ignored.
- R5: `rec_data` and `rec_ben` come from the sample on which `bus_xfer_n` rose. `rec_ben[i]` is the inverse of `bus_ben_n[i]` and marks byte lane i, which is data bits 8i+7..8i.
- R6: An access with `bus_cfgsel_n` low at the address latch is a setup access. Its record has `rec_setup`=1, `rec_addr` bits 23..3 zero and `rec_data` bits 31..8 zero.
- R7: A transfer start is dropped when no address latch has occurred since the last record, or when neither status line is low. A dropped start produces no record and raises `err_cnt` by one. `err_cnt` saturates at 2^ERR_W-1.
- R8: With `trig_mode`=0, a record matches when `rec_setup`=0, `rec_write`=`trig_write`, `rec_mem`=`trig_mem`, and `rec_addr` equals `trig_addr` on every bit set in `trig_mask`.
- R9: With `trig_mode`=1, any record with `rec_setup`=1 matches.
- R10: `trig_hit` rises one clock after the `rec_valid` of a matching record. It stays set until `trig_clr`, which clears it on the next clock and takes priority over a match in the same cycle.
- R11: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_xfer_n | input | 1 | Transfer strobe, active low |
| bus_alat_n | input | 1 | Address-latch strobe, active low |
| bus_wstat_n | input | 1 | Write status, active low |
| bus_rstat_n | input | 1 | Read status, active low |
| bus_mem_io | input | 1 | Space select, 1 = memory, 0 = I/O |
| bus_cfgsel_n | input | 1 | Card-setup select, active low |
| bus_addr | input | 24 | Address lines |
| bus_data | input | 32 | Data lines |
| bus_ben_n | input | 4 | Byte enables, active low |
| trig_mode | input | 1 | 0 = address pattern, 1 = first setup access |
| trig_addr | input | 24 | Trigger address |
| trig_mask | input | 24 | Address bits that take part in the compare |
| trig_write | input | 1 | Required direction in address mode |
| trig_mem | input | 1 | Required space in address mode |
| trig_clr | input | 1 | Clears the trigger flag |
| rec_valid | output | 1 | One-clock record strobe |
| rec_write | output | 1 | Record direction, 1 = write |
| rec_mem | output | 1 | Record space, 1 = memory |
| rec_setup | output | 1 | Record is a setup access |
| rec_addr | output | 24 | Record address |
| rec_data | output | 32 | Record data |
| rec_ben | output | 4 | Record byte enables, active high |
| err_cnt | output | 4 | Saturating count of dropped transfer starts |
| trig_hit | output | 1 | Sticky trigger flag |

## Verification
The bench drives the bus lines just after falling clock edges. A strobe edge driven before rising edge k shows up in `rec_valid`, the record fields and `err_cnt` after rising edge k+2. `trig_hit` follows one rising edge after that, and a clear shows after the next rising edge.

The behavioural reference model delays its view of the inputs by the same two samples plus one sample for edge detection. It decodes transfers from that delayed view. All outputs are then compared at every falling edge, half a period away from the edges where they change. Directed checks after each bus cycle wait at least five rising edges, so the record and the trigger flag have both settled.

// File: rtl/bxm_pkg.sv
package bxm_pkg;

    parameter int unsigned ADDR_W = 24;
    parameter int unsigned DATA_W = 32;
    parameter int unsigned LANES  = DATA_W / 8;

    // One sample of every observed bus line.
    typedef struct packed {
        logic              xfer_n;
        logic              alat_n;
        logic              wstat_n;
        logic              rstat_n;
        logic              mem_io;
        logic              cfg_n;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  ben_n;
    } bus_smp_t;

    localparam int unsigned SMP_W = $bits(bus_smp_t);

    localparam bus_smp_t SMP_IDLE = '{
        xfer_n: 1'b1, alat_n: 1'b1, wstat_n: 1'b1, rstat_n: 1'b1,
        mem_io: 1'b0, cfg_n: 1'b1, addr: '0, data: '0, ben_n: '1
    };

    // One decoded transfer.
    typedef struct packed {
        logic              write;
        logic              mem;
        logic              setup;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  ben;
    } xfer_rec_t;

endpackage

// File: rtl/bxm_sync.sv
module bxm_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] IDLE  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= IDLE;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/bxm_framer.sv
module bxm_framer
    import bxm_pkg::*;
#(
    parameter int unsigned ERR_W    = 4,
    parameter int unsigned SETUP_AW = 3,
    parameter int unsigned SETUP_DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_smp_t         smp,
    output logic             rec_valid,
    output xfer_rec_t        rec,
    output logic [ERR_W-1:0] err_cnt
);

    localparam logic [ADDR_W-1:0] SETUP_AMASK = {{(ADDR_W-SETUP_AW){1'b0}}, {SETUP_AW{1'b1}}};
    localparam logic [DATA_W-1:0] SETUP_DMASK = {{(DATA_W-SETUP_DW){1'b0}}, {SETUP_DW{1'b1}}};
    localparam logic [ERR_W-1:0]  ERR_MAX     = '1;

    typedef struct packed {
        logic              prev_xfer_n;
        logic              prev_alat_n;
        logic              addr_ok;
        logic              busy;
        logic              write;
        logic              mem;
        logic              setup;
        logic [ADDR_W-1:0] addr;
        logic [ERR_W-1:0]  err;
        logic              out_valid;
        xfer_rec_t         out;
    } fr_state_t;

    fr_state_t st_d, st_q;
    logic      alat_fall, xfer_fall, xfer_rise, status_ok;

    always_comb begin
        st_d             = st_q;
        st_d.out_valid   = 1'b0;
        st_d.prev_xfer_n = smp.xfer_n;
        st_d.prev_alat_n = smp.alat_n;

        alat_fall = st_q.prev_alat_n & ~smp.alat_n;
        xfer_fall = st_q.prev_xfer_n & ~smp.xfer_n;
        xfer_rise = ~st_q.prev_xfer_n & smp.xfer_n;
        status_ok = ~smp.wstat_n | ~smp.rstat_n;

        // Address phase: latched on the strobe edge, held while a transfer is open.
        if (alat_fall && !st_q.busy) begin
            st_d.addr_ok = 1'b1;
            st_d.addr    = smp.addr;
            st_d.mem     = smp.mem_io;
            st_d.setup   = ~smp.cfg_n;
        end

        // Transfer start: needs a latched address and a status line.
        if (xfer_fall && !st_q.busy) begin
            if (st_d.addr_ok && status_ok) begin
                st_d.busy  = 1'b1;
                st_d.write = ~smp.wstat_n;
            end else if (st_q.err != ERR_MAX) begin
                st_d.err = st_q.err + 1'b1;
            end
        end

        // Transfer end: data and lanes taken from this same sample.
        if (xfer_rise && st_q.busy) begin
            st_d.out_valid = 1'b1;
            st_d.out.write = st_q.write;
            st_d.out.mem   = st_q.mem;
            st_d.out.setup = st_q.setup;
            st_d.out.addr  = st_q.setup ? (st_q.addr & SETUP_AMASK) : st_q.addr;
            st_d.out.data  = st_q.setup ? (smp.data & SETUP_DMASK) : smp.data;
            st_d.out.ben   = ~smp.ben_n;
            st_d.busy      = 1'b0;
            st_d.addr_ok   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q             <= '0;
            st_q.prev_xfer_n <= 1'b1;
            st_q.prev_alat_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rec_valid = st_q.out_valid;
    assign rec       = st_q.out;
    assign err_cnt   = st_q.err;

endmodule

// File: rtl/bxm_trigger.sv
module bxm_trigger
    import bxm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    input  xfer_rec_t         rec,
    input  logic              mode,
    input  logic [ADDR_W-1:0] match_addr,
    input  logic [ADDR_W-1:0] match_mask,
    input  logic              want_write,
    input  logic              want_mem,
    input  logic              clr,
    output logic              hit
);

    typedef struct packed {
        logic hit;
    } tg_state_t;

    tg_state_t tg_d, tg_q;
    logic      addr_eq, attr_eq, match;

    always_comb begin
        tg_d    = tg_q;
        addr_eq = ((rec.addr ^ match_addr) & match_mask) == '0;
        attr_eq = (rec.write == want_write) && (rec.mem == want_mem);
        match   = mode ? rec.setup : (!rec.setup && attr_eq && addr_eq);
        if (clr) begin
            tg_d.hit = 1'b0;
        end else if (rec_valid && match) begin
            tg_d.hit = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tg_q <= '0;
        end else begin
            tg_q <= tg_d;
        end
    end

    assign hit = tg_q.hit;

endmodule

// File: rtl/bus_xact_monitor.sv
module bus_xact_monitor
    import bxm_pkg::*;
#(
    parameter int unsigned ERR_W       = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SETUP_AW    = 3,
    parameter int unsigned SETUP_DW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_xfer_n,
    input  logic              bus_alat_n,
    input  logic              bus_wstat_n,
    input  logic              bus_rstat_n,
    input  logic              bus_mem_io,
    input  logic              bus_cfgsel_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [LANES-1:0]  bus_ben_n,
    input  logic              trig_mode,
    input  logic [ADDR_W-1:0] trig_addr,
    input  logic [ADDR_W-1:0] trig_mask,
    input  logic              trig_write,
    input  logic              trig_mem,
    input  logic              trig_clr,
    output logic              rec_valid,
    output logic              rec_write,
    output logic              rec_mem,
    output logic              rec_setup,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [DATA_W-1:0] rec_data,
    output logic [LANES-1:0]  rec_ben,
    output logic [ERR_W-1:0]  err_cnt,
    output logic              trig_hit
);

    bus_smp_t          raw_smp;
    logic [SMP_W-1:0]  sync_vec;
    bus_smp_t          sync_smp;
    xfer_rec_t         rec;

    always_comb begin
        raw_smp.xfer_n  = bus_xfer_n;
        raw_smp.alat_n  = bus_alat_n;
        raw_smp.wstat_n = bus_wstat_n;
        raw_smp.rstat_n = bus_rstat_n;
        raw_smp.mem_io  = bus_mem_io;
        raw_smp.cfg_n   = bus_cfgsel_n;
        raw_smp.addr    = bus_addr;
        raw_smp.data    = bus_data;
        raw_smp.ben_n   = bus_ben_n;
    end

    bxm_sync #(
        .W      (SMP_W),
        .STAGES (SYNC_STAGES),
        .IDLE   (SMP_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_smp),
        .dout  (sync_vec)
    );

    assign sync_smp = bus_smp_t'(sync_vec);

    bxm_framer #(
        .ERR_W    (ERR_W),
        .SETUP_AW (SETUP_AW),
        .SETUP_DW (SETUP_DW)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp       (sync_smp),
        .rec_valid (rec_valid),
        .rec       (rec),
        .err_cnt   (err_cnt)
    );

    bxm_trigger u_trigger (
        .clk        (clk),
        .rst_n      (rst_n),
        .rec_valid  (rec_valid),
        .rec        (rec),
        .mode       (trig_mode),
        .match_addr (trig_addr),
        .match_mask (trig_mask),
        .want_write (trig_write),
        .want_mem   (trig_mem),
        .clr        (trig_clr),
        .hit        (trig_hit)
    );

    assign rec_write = rec.write;
    assign rec_mem   = rec.mem;
    assign rec_setup = rec.setup;
    assign rec_addr  = rec.addr;
    assign rec_data  = rec.data;
    assign rec_ben   = rec.ben;

endmodule

// File: rtl/bxm_checker.sv
module bxm_checker
    import bxm_pkg::*;
#(
    parameter int unsigned ERR_W    = 4,
    parameter int unsigned SETUP_AW = 3,
    parameter int unsigned SETUP_DW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rec_valid,
    input logic              rec_setup,
    input logic [ADDR_W-1:0] rec_addr,
    input logic [DATA_W-1:0] rec_data,
    input logic [ERR_W-1:0]  err_cnt,
    input logic              trig_clr,
    input logic              trig_hit
);

    localparam logic [ERR_W-1:0] ERR_TOP = '1;

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> !rec_valid);

    assert_setup_trim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_setup) |->
            (rec_addr[ADDR_W-1:SETUP_AW] == '0 && rec_data[DATA_W-1:SETUP_DW] == '0));

    assert_err_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt == ERR_TOP) |=> (err_cnt == ERR_TOP));

    assert_err_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt != ERR_TOP) |=>
            (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + 1'b1));

    assert_trig_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit && !trig_clr) |=> trig_hit);

    assert_trig_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trig_clr |=> !trig_hit);

    assert_trig_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_hit) |-> $past(rec_valid));

endmodule

bind bus_xact_monitor bxm_checker #(
    .ERR_W    (ERR_W),
    .SETUP_AW (SETUP_AW),
    .SETUP_DW (SETUP_DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_valid (rec_valid),
    .rec_setup (rec_setup),
    .rec_addr  (rec_addr),
    .rec_data  (rec_data),
    .err_cnt   (err_cnt),
    .trig_clr  (trig_clr),
    .trig_hit  (trig_hit)
);

// File: tb/bus_xact_monitor_tb.sv
`timescale 1ns/1ps
module bus_xact_monitor_tb;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic        bus_xfer_n, bus_alat_n, bus_wstat_n, bus_rstat_n, bus_mem_io, bus_cfgsel_n;
    logic [23:0] bus_addr;
    logic [31:0] bus_data;
    logic [3:0]  bus_ben_n;
    logic        trig_mode, trig_write, trig_mem, trig_clr;
    logic [23:0] trig_addr, trig_mask;
    logic        rec_valid, rec_write, rec_mem, rec_setup, trig_hit;
    logic [23:0] rec_addr;
    logic [31:0] rec_data;
    logic [3:0]  rec_ben;
    logic [3:0]  err_cnt;

    bus_xact_monitor u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_xfer_n(bus_xfer_n), .bus_alat_n(bus_alat_n),
        .bus_wstat_n(bus_wstat_n), .bus_rstat_n(bus_rstat_n),
        .bus_mem_io(bus_mem_io), .bus_cfgsel_n(bus_cfgsel_n),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_ben_n(bus_ben_n),
        .trig_mode(trig_mode), .trig_addr(trig_addr), .trig_mask(trig_mask),
        .trig_write(trig_write), .trig_mem(trig_mem), .trig_clr(trig_clr),
        .rec_valid(rec_valid), .rec_write(rec_write), .rec_mem(rec_mem),
        .rec_setup(rec_setup), .rec_addr(rec_addr), .rec_data(rec_data),
        .rec_ben(rec_ben), .err_cnt(err_cnt), .trig_hit(trig_hit)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct packed {
        logic        xf, al, ws, rs, mem, cfg;
        logic [23:0] a;
        logic [31:0] d;
        logic [3:0]  be;
    } obs_t;

    localparam obs_t OBS_IDLE = '{xf:1, al:1, ws:1, rs:1, mem:0, cfg:1, a:0, d:0, be:4'hF};

    obs_t        seen [$];
    obs_t        cur, old, now_in;
    logic        m_have, m_busy, m_wr, m_mem, m_setup, m_trig;
    logic [23:0] m_addr;
    int          m_err;
    logic        e_valid, e_wr, e_mem, e_setup;
    logic [23:0] e_addr;
    logic [31:0] e_data;
    logic [3:0]  e_ben;

    function automatic logic model_match();
        if (trig_mode) return e_setup;
        return !e_setup && (e_wr == trig_write) && (e_mem == trig_mem) &&
               (((e_addr ^ trig_addr) & trig_mask) == 24'h0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            seen.delete();
            for (int i = 0; i < 3; i++) seen.push_back(OBS_IDLE);
            m_have = 0; m_busy = 0; m_wr = 0; m_mem = 0; m_setup = 0; m_trig = 0;
            m_addr = 0; m_err = 0;
            e_valid = 0; e_wr = 0; e_mem = 0; e_setup = 0; e_addr = 0; e_data = 0; e_ben = 0;
        end else begin
            // trigger looks at the record shown during the last cycle (R10)
            if (trig_clr) m_trig = 0;
            else if (e_valid && model_match()) m_trig = 1;
            e_valid = 0;
            // seen[0] is three samples old, seen[1] two samples old (R1)
            old = seen[0];
            cur = seen[1];
            if (old.al && !cur.al && !m_busy) begin
                m_have = 1; m_addr = cur.a; m_mem = cur.mem; m_setup = !cur.cfg;
            end
            if (old.xf && !cur.xf && !m_busy) begin
                if (m_have && (!cur.ws || !cur.rs)) begin
                    m_busy = 1; m_wr = !cur.ws;
                end else if (m_err < 15) begin
                    m_err++;
                end
            end
            if (!old.xf && cur.xf && m_busy) begin
                e_valid = 1; e_wr = m_wr; e_mem = m_mem; e_setup = m_setup;
                e_addr = m_setup ? (m_addr & 24'h7) : m_addr;
                e_data = m_setup ? (cur.d & 32'hFF) : cur.d;
                e_ben  = ~cur.be;
                m_busy = 0; m_have = 0;
            end
            now_in = '{xf:bus_xfer_n, al:bus_alat_n, ws:bus_wstat_n, rs:bus_rstat_n,
                       mem:bus_mem_io, cfg:bus_cfgsel_n, a:bus_addr, d:bus_data, be:bus_ben_n};
            void'(seen.pop_front());
            seen.push_back(now_in);
        end
    end

    // compare on every clock, half a period away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1 R2 rec_valid", rec_valid, e_valid);
            if (e_valid) begin
                chk("R3 rec_write", rec_write, e_wr);
                chk("R4 rec_mem", rec_mem, e_mem);
                chk("R4 R6 rec_setup", rec_setup, e_setup);
                chk("R4 R6 rec_addr", rec_addr, e_addr);
                chk("R5 R6 rec_data", rec_data, e_data);
                chk("R5 rec_ben", rec_ben, e_ben);
            end
            chk("R7 err_cnt", err_cnt, m_err);
            chk("R8 R9 R10 trig_hit", trig_hit, m_trig);
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_cycle(input logic wr, input logic mem, input logic setup,
                             input logic [23:0] a, input logic [31:0] d, input logic [3:0] ben_n,
                             input logic do_latch, input logic no_status);
        step(1);
        bus_addr = a; bus_mem_io = mem; bus_cfgsel_n = !setup;
        bus_wstat_n = no_status ? 1'b1 : !wr;
        bus_rstat_n = no_status ? 1'b1 : wr;
        step(2);
        if (do_latch) bus_alat_n = 1'b0;
        step(2);
        bus_alat_n = 1'b1;
        bus_addr = ~a; bus_mem_io = !mem; bus_cfgsel_n = setup;   // R4: late changes ignored
        step(1);
        bus_xfer_n = 1'b0;
        step(2);
        bus_data = ~d; bus_ben_n = ~ben_n;                        // R5: early values replaced
        step(2);
        bus_data = d; bus_ben_n = ben_n;
        step(1);
        bus_xfer_n = 1'b1;
        step(1);
        bus_data = 32'h5A5A_A5A5; bus_ben_n = 4'hF;
        bus_wstat_n = 1'b1; bus_rstat_n = 1'b1; bus_cfgsel_n = 1'b1; bus_mem_io = 1'b0;
        step(4);
    endtask

    task automatic pulse_clear();
        trig_clr = 1'b1;
        step(1);
        trig_clr = 1'b0;
        step(1);
    endtask

    initial begin
        rst_n = 1'b0;
        bus_xfer_n = 1; bus_alat_n = 1; bus_wstat_n = 1; bus_rstat_n = 1;
        bus_mem_io = 0; bus_cfgsel_n = 1; bus_addr = 0; bus_data = 0; bus_ben_n = 4'hF;
        trig_mode = 0; trig_addr = 24'h000600; trig_mask = 24'hFFFFFF;
        trig_write = 1; trig_mem = 0; trig_clr = 0;
        step(4);
        // R11: reset state
        chk("R11 reset outputs",
            {rec_valid, rec_write, rec_mem, rec_setup, rec_addr, rec_data, rec_ben, err_cnt, trig_hit},
            '0);
        rst_n = 1'b1;
        step(3);

        // R8: near misses on direction, space and address
        bus_cycle(0, 0, 0, 24'h000600, 32'h1111_2222, 4'h0, 1, 0);
        bus_cycle(1, 1, 0, 24'h000600, 32'h3333_4444, 4'h0, 1, 0);
        bus_cycle(1, 0, 0, 24'h000601, 32'h5555_6666, 4'h0, 1, 0);
        chk("R8 no trigger on near misses", trig_hit, 1'b0);
        bus_cycle(1, 0, 0, 24'h000600, 32'h1234_5678, 4'h0, 1, 0);
        chk("R8 trigger on I/O write to 0x600", trig_hit, 1'b1);
        chk("R3 R5 last record data", rec_data, 32'h1234_5678);
        bus_cycle(0, 1, 0, 24'hABCDEF, 32'h0BAD_F00D, 4'hA, 1, 0);
        chk("R10 trigger stays set", trig_hit, 1'b1);
        chk("R5 byte lanes inverted", rec_ben, 4'h5);
        pulse_clear();
        chk("R10 trigger cleared", trig_hit, 1'b0);

        // R8: masked compare
        trig_addr = 24'h0006F0; trig_mask = 24'hFFFFF0; trig_mem = 1;
        bus_cycle(1, 1, 0, 24'h0006F3, 32'hFEED_0001, 4'h3, 1, 0);
        chk("R8 masked address match", trig_hit, 1'b1);
        pulse_clear();

        // R9, R6: first setup access
        trig_mode = 1;
        bus_cycle(1, 0, 0, 24'h000100, 32'h0000_0001, 4'h0, 1, 0);
        chk("R9 no trigger on normal access", trig_hit, 1'b0);
        bus_cycle(1, 0, 1, 24'hABCDE5, 32'hCAFE_F00D, 4'h0, 1, 0);
        chk("R9 trigger on setup access", trig_hit, 1'b1);
        chk("R6 setup address trimmed", rec_addr, 24'h000005);
        chk("R6 setup data trimmed", rec_data, 32'h0000_000D);
        chk("R6 setup flag", rec_setup, 1'b1);
        pulse_clear();

        // R7: dropped starts saturate the counter
        bus_cycle(1, 0, 0, 24'h000200, 32'h0, 4'h0, 1, 1);
        chk("R7 start without status dropped", err_cnt, 4'd1);
        bus_cycle(1, 0, 0, 24'h000200, 32'h77, 4'h0, 1, 0);
        for (int i = 0; i < 17; i++) begin
            bus_cycle(1, 0, 0, 24'h000300, 32'h88, 4'h0, 0, 0);
        end
        chk("R7 counter saturates", err_cnt, 4'd15);
        chk("R7 no record after dropped starts", trig_hit, 1'b0);

        // R3: plain read record
        trig_mode = 0; trig_write = 0; trig_mem = 0; trig_addr = 24'h000040; trig_mask = 24'hFFFFFF;
        bus_cycle(0, 0, 0, 24'h000040, 32'h9988_7766, 4'hC, 1, 0);
        chk("R3 read direction", rec_write, 1'b0);
        chk("R8 read-trigger match", trig_hit, 1'b1);

        step(5);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule